// File: doc/BRIEF.md
# Reloading Line/Pixel Timer with Dual-CPU Interrupt Controller

This block pairs a 12-bit reloadable up-counter with a five-level interrupt priority encoder that serves two processors. The counter can be clocked from a half-pixel-rate enable or from a once-per-line pulse. In one mode the counter also restarts on every line pulse, which gives an interrupt at a chosen position within a scan line. When the counter wraps past its all-ones value it loads a software-supplied start value and raises a timer request. That request stays pending for each CPU until that CPU's enable register is touched.

Software sees four word registers through a simple valid/write strobe port: the counter start value, the 2-bit mode, and one enable mask per CPU. A read at any offset returns the live count. Four active-low external lines provide the other interrupt sources. For each CPU the block drives a registered 3-bit code that names the highest pending source that CPU has enabled.

Top module: `tick_irq_ctrl`

## Requirements
- R1: After reset both level outputs are 0, the count is 0, the start value is 0, the mode is off (0) and both enable masks are clear.
- R2: A read (bus_vld=1, bus_wr=0) at any offset 0..3 returns the count as it was in the access cycle, zero-extended to 16 bits, on bus_rdata one clock later. A read changes no count or register.
- R3: Offset 1 bits 1:0 hold the mode. In mode 3 the count rises by one for every cycle with half_en high. In mode 1 it rises by one on each rising edge of line_in, and half_en has no effect.
- R4: A counting edge that arrives while the count is 0xFFF loads the start value and raises a timer request (level 3) for both CPUs.
- R5: Offset 0 bits 11:0 hold the start value. Writing it does not change the running count, and the new value is used only at the next load.
- R6: In mode 2, half_en drives the count and each rising edge of line_in loads the start value; that load wins over a half_en count in the same cycle. A line_in held high loads only once.
- R7: In mode 0 the count holds. Each rising edge of line_in raises a timer request only if the start value is 0xFFF, and never otherwise.
- R8: A CPU's timer request stays pending until any read or write of its enable register (offset 2 for CPU A, offset 3 for CPU B). Such an access clears only that CPU's request, and the count keeps running while a request is unserved.
- R9: Each level output, one clock after its inputs, equals the highest level n in 2..6 that is requested and whose enable bit n (bits 6:2 of offset 2 or 3) is set, or 0 if there is none. Active-low ext_irq_n[0], [1], [2] and [3] request levels 2, 4, 5 and 6 only while they are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_vld | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (live count), registered |
| half_en | input | 1 | Half-pixel-rate counting enable |
| line_in | input | 1 | Once-per-line pulse |
| ext_irq_n | input | 4 | Active-low external requests for levels 2, 4, 5, 6 |
| lvl_a | output | 3 | Encoded level for CPU A |
| lvl_b | output | 3 | Encoded level for CPU B |

## Verification
The bench drives the counter up to 0xFFF and checks that no request appears before the wrapping edge. It then checks that a start value written mid-count is held back until the load, since a design that loaded it at once would show the new value on the next read. The acknowledge tests clear one CPU's request and check that the other CPU's level is untouched; a design that shared one request flag would drop both. It also holds line_in high while half_en runs in mode 2, which catches a level-triggered reload (the count would freeze), and it checks the mode 0 quirk for both a 0xFFF start value and any other value.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_LINE  = 2'd1,
    MODE_SPLIT = 2'd2,
    MODE_FREE  = 2'd3
  } tmode_e;

  localparam int LVL_W  = 3;
  localparam int LVL_LO = 2;
  localparam int SRC_N  = 5;
  localparam int TMR_IDX = 1;

endpackage

// File: rtl/tick_counter.sv
module tick_counter
  import tick_irq_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  tmode_e           mode,
  input  logic [CNT_W-1:0] reload,
  input  logic             half_en,
  input  logic             line_in,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tick_en,
  output logic             line_rise,
  output logic             tmr_evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic line_q;
  logic wrap;
  logic quirk;

  always_ff @(posedge clk) begin
    if (rst) line_q <= 1'b0;
    else     line_q <= line_in;
  end

  assign line_rise = line_in & ~line_q;

  always_comb begin
    case (mode)
      MODE_LINE:             tick_en = line_rise;
      MODE_SPLIT, MODE_FREE: tick_en = half_en;
      default:               tick_en = 1'b0;
    endcase
  end

  assign wrap    = tick_en && (cnt_q == CNT_MAX);
  assign quirk   = (mode == MODE_OFF) && (reload == CNT_MAX) && line_rise;
  assign tmr_evt = wrap | quirk;

  always_ff @(posedge clk) begin
    if (rst)                                 cnt_q <= '0;
    else if (wrap)                           cnt_q <= reload;
    else if (mode == MODE_SPLIT && line_rise) cnt_q <= reload;
    else if (tick_en)                        cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/tick_irq_regs.sv
module tick_irq_regs
  import tick_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 2,
  parameter int NCPU   = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bus_vld,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [DATA_W-1:0]               bus_wdata,
  input  logic [CNT_W-1:0]                cnt_q,
  output logic [CNT_W-1:0]                reload_q,
  output tmode_e                          mode_q,
  output logic [NCPU-1:0][SRC_N-1:0]      mask_q,
  output logic [NCPU-1:0]                 ack,
  output logic [DATA_W-1:0]               bus_rdata
);

  localparam int OFS_RELOAD = 0;
  localparam int OFS_MODE   = 1;
  localparam int OFS_EN0    = 2;

  logic wr_stb;
  logic rd_stb;

  assign wr_stb = bus_vld & bus_wr;
  assign rd_stb = bus_vld & ~bus_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      mode_q   <= MODE_OFF;
    end else if (wr_stb) begin
      if (bus_addr == ADDR_W'(OFS_RELOAD)) reload_q <= bus_wdata[CNT_W-1:0];
      if (bus_addr == ADDR_W'(OFS_MODE))   mode_q   <= tmode_e'(bus_wdata[1:0]);
    end
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_en
    localparam logic [ADDR_W-1:0] MY_OFS = ADDR_W'(OFS_EN0 + i);
    assign ack[i] = bus_vld && (bus_addr == MY_OFS);
    always_ff @(posedge clk) begin
      if (rst)                               mask_q[i] <= '0;
      else if (wr_stb && bus_addr == MY_OFS) mask_q[i] <= bus_wdata[LVL_LO +: SRC_N];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_stb) bus_rdata <= DATA_W'(cnt_q);
  end

endmodule

// File: rtl/tick_irq_prio.sv
module tick_irq_prio
  import tick_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  input  logic             tmr_evt,
  input  logic [SRC_N-1:0] ext_req,
  input  logic [SRC_N-1:0] mask,
  output logic             pend_q,
  output logic [LVL_W-1:0] lvl_q
);

  logic [SRC_N-1:0] req;
  logic [LVL_W-1:0] enc;

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= 1'b0;
    else if (tmr_evt) pend_q <= 1'b1;
    else if (ack)     pend_q <= 1'b0;
  end

  always_comb begin
    req          = ext_req;
    req[TMR_IDX] = pend_q;
    enc          = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (req[i] && mask[i]) enc = LVL_W'(LVL_LO + i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= enc;
  end

endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
  import tick_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 2,
  parameter int EXT_N  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              half_en,
  input  logic              line_in,
  input  logic [EXT_N-1:0]  ext_irq_n,
  output logic [LVL_W-1:0]  lvl_a,
  output logic [LVL_W-1:0]  lvl_b
);

  localparam int NCPU = 2;

  logic [CNT_W-1:0]           cnt_q;
  logic [CNT_W-1:0]           reload_q;
  tmode_e                     mode_q;
  logic [NCPU-1:0][SRC_N-1:0] mask_q;
  logic [NCPU-1:0]            ack;
  logic [NCPU-1:0]            pend_vec;
  logic [NCPU-1:0][LVL_W-1:0] lvl_vec;
  logic                       tick_en;
  logic                       line_rise;
  logic                       tmr_evt;
  logic [SRC_N-1:0]           ext_req;

  tick_irq_regs #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .NCPU   (NCPU)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_vld   (bus_vld),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_q     (cnt_q),
    .reload_q  (reload_q),
    .mode_q    (mode_q),
    .mask_q    (mask_q),
    .ack       (ack),
    .bus_rdata (bus_rdata)
  );

  tick_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .reload    (reload_q),
    .half_en   (half_en),
    .line_in   (line_in),
    .cnt_q     (cnt_q),
    .tick_en   (tick_en),
    .line_rise (line_rise),
    .tmr_evt   (tmr_evt)
  );

  // External lines fill every source slot except the timer slot.
  always_comb begin
    ext_req = '0;
    for (int j = 0; j < EXT_N; j++) begin
      if (j < TMR_IDX) ext_req[j]     = ~ext_irq_n[j];
      else             ext_req[j + 1] = ~ext_irq_n[j];
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    tick_irq_prio u_prio (
      .clk     (clk),
      .rst     (rst),
      .ack     (ack[c]),
      .tmr_evt (tmr_evt),
      .ext_req (ext_req),
      .mask    (mask_q[c]),
      .pend_q  (pend_vec[c]),
      .lvl_q   (lvl_vec[c])
    );
  end

  assign lvl_a = lvl_vec[0];
  assign lvl_b = lvl_vec[1];

endmodule

// File: rtl/tick_irq_chk.sv
module tick_irq_chk
  import tick_irq_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_vld,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LVL_W-1:0]  lvl_a,
  input logic [LVL_W-1:0]  lvl_b,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic [1:0]        mode_q,
  input logic [SRC_N-1:0]  mask_a,
  input logic              pend_a,
  input logic              tick_en,
  input logic              line_rise,
  input logic              tmr_evt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R7
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd0) |=> $stable(cnt_q));

  // R3
  line_only_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 2'd1 && !line_rise) |=> $stable(cnt_q));

  // R4
  wrap_load_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && cnt_q == CNT_MAX) |=> (cnt_q == $past(reload_q)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_vld && bus_addr == ADDR_W'(2) && !tmr_evt) |=> !pend_a);

  // R4
  evt_pend_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_evt |=> pend_a);

  // R9
  mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_a) == '0) |-> (lvl_a == '0));

  // R9
  lvl_range_chk: assert property (@(posedge clk) disable iff (rst)
    (lvl_a != 3'd1 && lvl_a != 3'd7 && lvl_b != 3'd1 && lvl_b != 3'd7));

endmodule

bind tick_irq_ctrl tick_irq_chk #(
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_vld   (bus_vld),
  .bus_addr  (bus_addr),
  .lvl_a     (lvl_a),
  .lvl_b     (lvl_b),
  .cnt_q     (cnt_q),
  .reload_q  (reload_q),
  .mode_q    (mode_q),
  .mask_a    (mask_q[0]),
  .pend_a    (pend_vec[0]),
  .tick_en   (tick_en),
  .line_rise (line_rise),
  .tmr_evt   (tmr_evt)
);

// File: tb/tick_irq_ctrl_tb.sv
module tick_irq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_vld;
  logic        bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        half_en;
  logic        line_in;
  logic [3:0]  ext_irq_n;
  logic [2:0]  lvl_a;
  logic [2:0]  lvl_b;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  tick_irq_ctrl u_dut (
    .clk       (clk),
    .rst       (rst),
    .bus_vld   (bus_vld),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .half_en   (half_en),
    .line_in   (line_in),
    .ext_irq_n (ext_irq_n),
    .lvl_a     (lvl_a),
    .lvl_b     (lvl_b)
  );

  // {ext_irq_n[3:0], enable mask byte, 1'b0, expected level[2:0]}
  localparam logic [15:0] VEC [8] = '{
    {4'b1111, 8'h7C, 1'b0, 3'd0},
    {4'b1110, 8'h7C, 1'b0, 3'd2},
    {4'b0000, 8'h7C, 1'b0, 3'd6},
    {4'b0000, 8'h3C, 1'b0, 3'd5},
    {4'b0000, 8'h04, 1'b0, 3'd2},
    {4'b1101, 8'h6C, 1'b0, 3'd0},
    {4'b1001, 8'h7C, 1'b0, 3'd5},
    {4'b0101, 8'h10, 1'b0, 3'd4}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_acc(input logic wr, input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_vld = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input int exp);
    bus_acc(1'b0, a, 16'h0);
    chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    half_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    half_en = 1'b0;
  endtask

  task automatic line_pulse();
    @(negedge clk);
    line_in = 1'b1;
    @(negedge clk);
    line_in = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; bus_vld = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    half_en = 1'b0; line_in = 1'b0; ext_irq_n = 4'hF;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 lvl_a", lvl_a, 0);
    chk("R1 lvl_b", lvl_b, 0);
    rd_chk("R1 count", 2'd0, 0);

    // R9 vector table (timer idle, CPU B mask clear)
    for (int v = 0; v < 8; v++) begin
      bus_acc(1'b1, 2'd2, {8'h00, VEC[v][11:4]});
      @(negedge clk);
      ext_irq_n = VEC[v][15:12];
      idle(2);
      chk($sformatf("R9 vec%0d lvl_a", v), lvl_a, int'(VEC[v][2:0]));
      chk($sformatf("R9 vec%0d lvl_b", v), lvl_b, 0);
    end
    ext_irq_n = 4'hF;

    // R3 / R2 free-running mode, read at every offset
    bus_acc(1'b1, 2'd1, 16'h0003);
    tick(10);
    for (int a = 0; a < 4; a++) rd_chk($sformatf("R2 off%0d", a), 2'(a), 16'h000A);

    // R4 approach and wrap
    bus_acc(1'b1, 2'd0, 16'h0FF0);
    bus_acc(1'b1, 2'd2, 16'h0008);
    bus_acc(1'b1, 2'd3, 16'h0008);
    tick(4085);
    rd_chk("R3 at max", 2'd0, 16'h0FFF);
    chk("R4 no req before wrap", lvl_a, 0);
    tick(1);
    idle(1);
    chk("R4 lvl_a after wrap", lvl_a, 3);
    chk("R4 lvl_b after wrap", lvl_b, 3);
    rd_chk("R4 loaded", 2'd1, 16'h0FF0);

    // R5 deferred start value; R8 count runs while pending
    bus_acc(1'b1, 2'd0, 16'h0FFA);
    rd_chk("R5 write no effect", 2'd0, 16'h0FF0);
    tick(16);
    rd_chk("R5 new value at load", 2'd0, 16'h0FFA);
    chk("R8 still pending", lvl_a, 3);

    // R8 acknowledge per CPU
    rd_chk("R8 ack read", 2'd2, 16'h0FFA);
    idle(1);
    chk("R8 lvl_a cleared", lvl_a, 0);
    chk("R8 lvl_b kept", lvl_b, 3);
    bus_acc(1'b1, 2'd3, 16'h0008);
    idle(1);
    chk("R8 lvl_b cleared by write", lvl_b, 0);

    // R3 line mode
    bus_acc(1'b1, 2'd1, 16'h0001);
    tick(5);
    rd_chk("R3 half_en ignored", 2'd0, 16'h0FFA);
    repeat (5) line_pulse();
    rd_chk("R3 line counts", 2'd0, 16'h0FFF);
    line_pulse();
    rd_chk("R4 line wrap", 2'd0, 16'h0FFA);
    chk("R4 line wrap lvl_a", lvl_a, 3);
    bus_acc(1'b0, 2'd2, 16'h0);
    bus_acc(1'b0, 2'd3, 16'h0);

    // R6 split mode
    bus_acc(1'b1, 2'd1, 16'h0002);
    bus_acc(1'b1, 2'd0, 16'h0100);
    tick(3);
    rd_chk("R6 half_en counts", 2'd0, 16'h0FFD);
    line_pulse();
    rd_chk("R6 line reload", 2'd0, 16'h0100);
    tick(2);
    @(negedge clk);
    line_in = 1'b1; half_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    line_in = 1'b0; half_en = 1'b0;
    rd_chk("R6 held line single reload", 2'd0, 16'h0102);
    chk("R6 no timer req", lvl_a, 0);

    // R7 off mode and the 0xFFF quirk
    bus_acc(1'b1, 2'd1, 16'h0000);
    tick(3);
    line_pulse();
    rd_chk("R7 frozen", 2'd0, 16'h0102);
    chk("R7 no req", lvl_a, 0);
    bus_acc(1'b1, 2'd0, 16'h0FFF);
    line_pulse();
    chk("R7 quirk lvl_a", lvl_a, 3);
    chk("R7 quirk lvl_b", lvl_b, 3);
    rd_chk("R7 quirk count held", 2'd0, 16'h0102);

    // R9 masked external source with timer pending
    @(negedge clk);
    ext_irq_n = 4'b0111;
    idle(2);
    chk("R9 masked L6", lvl_a, 3);
    ext_irq_n = 4'hF;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule